// File: doc/BRIEF.md
# Single-Channel DMA Transfer Controller

This block runs one DMA channel from a control register. A hardware request line records a pending request in a flag. When the channel is enabled, each pending request moves one unit from a source address to a destination address over a simple valid/ready memory bus. The move is a read cycle followed by a write cycle. After each unit, both addresses are updated and a transfer counter counts down.

In normal mode, the counter underflow clears the enable bit and raises a one-cycle done pulse. In ring mode, the underflow instead reloads the addresses and the counter, and the channel keeps running.

Firmware programs the channel through a four-entry register port. Entry 0 is control. Entry 1 is the source address. Entry 2 is the destination address. Entry 3 is the transfer count. Every entry reads back its live value.

Top module: `sdma_channel`

## Requirements
- R1: After reset, the control entry reads 0, the count entry reads 0, `mem_req` is low and `done` is low.
- R2: The pending flag (control bit 1) becomes 1 at the clock edge where the request input picked by control bits 3:2 is high. This happens whether or not the enable bit is set. The other request inputs have no effect on the flag.
- R3: A control write with bit 1 = 0 clears the pending flag. A control write with bit 1 = 1 keeps the flag's value. If a write of 0 and a request fall in the same cycle, the flag ends at 0. In all register writes, the software value overrides any hardware update in that cycle.
- R4: While the flag is 1, or while a transfer is in flight, new requests are not latched. Hardware clears the flag in the cycle the write phase completes.
- R5: In the cycle after the flag and the enable bit (control bit 4) are both 1 with the bus idle, `mem_req` rises with a read. This includes the case where the flag was set before enable was written.
- R6: Clearing the enable bit during an accepted transfer does not abort it. The transfer finishes and updates addresses and count.
- R7: A transfer reads at the current source address (`mem_we`=0) and then writes the read data at the current destination address (`mem_we`=1). Each phase holds until `mem_ready`. When control bit 5 is 1, the unit is a byte: `mem_byte`=1 and the write data is the low read byte with the upper 8 bits zero. When bit 5 is 0, all 16 bits are moved.
- R8: Control bit 6 (source) and control bit 7 (destination) select incrementing (1) or fixed (0). An incrementing address advances by 1 for byte units and by 2 for 16-bit units. Entries 1 and 2 read back the current address.
- R9: Normal mode (control bit 0 = 0) behaves as follows after each transfer:
  - If the count was non-zero, it is decremented.
  - If the count was zero, the count reads all ones, the enable bit clears, and `done` pulses high for one cycle.
  - A count of N therefore gives N+1 transfers.
- R10: Ring mode (control bit 0 = 1) behaves as follows after a transfer with count zero:
  - The count reloads its last written value.
  - Both addresses return to their last written values.
  - The channel stays enabled and no `done` pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_in | input | NSRC | Hardware request lines |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 control, 1 source, 2 destination, 3 count |
| cfg_wdata | input | AW | Register write data |
| cfg_rdata | output | AW | Register read data for `cfg_addr` |
| mem_req | output | 1 | Bus request valid |
| mem_we | output | 1 | 1 for the write phase, 0 for the read phase |
| mem_byte | output | 1 | 1 when the unit is a byte |
| mem_addr | output | AW | Bus address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, taken when `mem_ready` is high in the read phase |
| mem_ready | input | 1 | Bus completes the current phase |
| done | output | 1 | One-cycle pulse on normal-mode underflow |

## Verification
The pending flag has two setters and clearers that can land in the same cycle. A firmware control write and a hardware request can both arrive at once, and a write-phase completion can coincide with a new request. The bench raises a request in the same cycle as a control write with bit 1 = 0, and also while a transfer is stalled by a held-low `mem_ready`. It then reads the flag back through the control entry and expects it to be 0 in both cases. A behavioural reference model, run on every clock under random requests and random ready stalls, judges the same coincidences in bulk.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
   typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} sdma_state_e;

   // control entry layout, most significant field first
   typedef struct packed {
      logic       dst_inc;
      logic       src_inc;
      logic       byte_unit;
      logic       enable;
      logic [1:0] src_sel;
      logic       pending;
      logic       ring;
   } sdma_ctl_t;

   localparam int CTL_W   = 8;
   localparam int BUS_DW  = 16;
   localparam int MAX_SRC = 4;

   localparam logic [1:0] REG_CTL = 2'd0;
   localparam logic [1:0] REG_SRC = 2'd1;
   localparam logic [1:0] REG_DST = 2'd2;
   localparam logic [1:0] REG_CNT = 2'd3;
endpackage

// File: rtl/sdma_regs.sv
module sdma_regs
   import sdma_pkg::*;
#(
   parameter int CW = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_ctl,
   input  logic             wr_cnt,
   input  logic [CTL_W-1:0] wdata_ctl,
   input  logic [CW-1:0]    wdata_cnt,
   input  logic             req_line,
   input  logic             busy,
   input  logic             xfer_done,
   output sdma_ctl_t        ctl,
   output logic [CW-1:0]    cnt,
   output logic             wrap,
   output logic             done
);
   sdma_ctl_t     ctl_q, ctl_n;
   logic [CW-1:0] cnt_q, cnt_n, rel_q, rel_n;
   logic          last, fin, keep;

   assign last = (cnt_q == '0);
   assign fin  = xfer_done && last && !ctl_q.ring;
   assign wrap = xfer_done && last && ctl_q.ring;

   always_comb begin
      ctl_n = ctl_q;
      cnt_n = cnt_q;
      rel_n = rel_q;
      keep  = 1'b0;
      if (req_line && !ctl_q.pending && !busy) ctl_n.pending = 1'b1;
      if (xfer_done) begin
         ctl_n.pending = 1'b0;
         if (!last)          cnt_n = cnt_q - 1'b1;
         else if (ctl_q.ring) cnt_n = rel_q;
         else                 cnt_n = '1;
      end
      if (fin) ctl_n.enable = 1'b0;
      if (wr_ctl) begin
         keep          = ctl_n.pending;
         ctl_n         = sdma_ctl_t'(wdata_ctl);
         ctl_n.pending = wdata_ctl[1] & keep;
      end
      if (wr_cnt) begin
         cnt_n = wdata_cnt;
         rel_n = wdata_cnt;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
         cnt_q <= '0;
         rel_q <= '0;
         done  <= 1'b0;
      end else begin
         ctl_q <= ctl_n;
         cnt_q <= cnt_n;
         rel_q <= rel_n;
         done  <= fin;
      end
   end

   assign ctl = ctl_q;
   assign cnt = cnt_q;
endmodule

// File: rtl/sdma_ptr.sv
module sdma_ptr #(
   parameter int AW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] load_val,
   input  logic          inc_en,
   input  logic          byte_step,
   input  logic          advance,
   input  logic          reload,
   output logic [AW-1:0] cur
);
   logic [AW-1:0] start_q, cur_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q <= '0;
         cur_q   <= '0;
      end else if (load) begin
         start_q <= load_val;
         cur_q   <= load_val;
      end else if (reload) begin
         cur_q <= start_q;
      end else if (advance && inc_en) begin
         cur_q <= cur_q + (byte_step ? AW'(1) : AW'(2));
      end
   end

   assign cur = cur_q;
endmodule

// File: rtl/sdma_engine.sv
module sdma_engine
   import sdma_pkg::*;
#(
   parameter int AW = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic              byte_unit,
   input  logic [AW-1:0]     src,
   input  logic [AW-1:0]     dst,
   input  logic              mem_ready,
   input  logic [BUS_DW-1:0] mem_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic              mem_byte,
   output logic [AW-1:0]     mem_addr,
   output logic [BUS_DW-1:0] mem_wdata,
   output logic              busy,
   output logic              xfer_done
);
   sdma_state_e       st_q;
   logic [BUS_DW-1:0] data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         data_q <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE: if (go) st_q <= ST_RD;
            ST_RD:   if (mem_ready) begin
                        data_q <= mem_rdata;
                        st_q   <= ST_WR;
                     end
            ST_WR:   if (mem_ready) st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign busy      = (st_q != ST_IDLE);
   assign mem_req   = busy;
   assign mem_we    = (st_q == ST_WR);
   assign mem_byte  = byte_unit;
   assign mem_addr  = mem_we ? dst : src;
   assign mem_wdata = byte_unit ? {8'h00, data_q[7:0]} : data_q;
   assign xfer_done = mem_we && mem_ready;
endmodule

// File: rtl/sdma_channel.sv
module sdma_channel
   import sdma_pkg::*;
#(
   parameter int AW   = 16,
   parameter int CW   = 8,
   parameter int NSRC = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-1:0]   req_in,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_addr,
   input  logic [AW-1:0]     cfg_wdata,
   output logic [AW-1:0]     cfg_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic              mem_byte,
   output logic [AW-1:0]     mem_addr,
   output logic [BUS_DW-1:0] mem_wdata,
   input  logic [BUS_DW-1:0] mem_rdata,
   input  logic              mem_ready,
   output logic              done
);
   localparam int NPTR = 2;

   initial begin
      assert (AW >= CTL_W && CW >= 1 && CW <= AW && NSRC >= 1 && NSRC <= MAX_SRC)
         else $fatal(1, "sdma_channel: unsupported parameter set");
   end

   sdma_ctl_t        ctl_q;
   logic [CW-1:0]    cnt_q;
   logic [MAX_SRC-1:0] req_pad;
   logic             req_line, busy, xfer_done, wrap;
   logic [AW-1:0]    ptr_cur [NPTR];
   logic             ptr_inc [NPTR];

   // unused request slots read as idle
   for (genvar i = 0; i < MAX_SRC; i++) begin : g_req
      if (i < NSRC) begin : g_live
         assign req_pad[i] = req_in[i];
      end else begin : g_tied
         assign req_pad[i] = 1'b0;
      end
   end
   assign req_line = req_pad[ctl_q.src_sel];

   sdma_regs #(.CW(CW)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_ctl    (cfg_we && cfg_addr == REG_CTL),
      .wr_cnt    (cfg_we && cfg_addr == REG_CNT),
      .wdata_ctl (cfg_wdata[CTL_W-1:0]),
      .wdata_cnt (cfg_wdata[CW-1:0]),
      .req_line  (req_line),
      .busy      (busy),
      .xfer_done (xfer_done),
      .ctl       (ctl_q),
      .cnt       (cnt_q),
      .wrap      (wrap),
      .done      (done)
   );

   assign ptr_inc[0] = ctl_q.src_inc;
   assign ptr_inc[1] = ctl_q.dst_inc;

   for (genvar p = 0; p < NPTR; p++) begin : g_ptr
      sdma_ptr #(.AW(AW)) u_ptr (
         .clk       (clk),
         .rst_n     (rst_n),
         .load      (cfg_we && cfg_addr == REG_SRC + 2'(p)),
         .load_val  (cfg_wdata),
         .inc_en    (ptr_inc[p]),
         .byte_step (ctl_q.byte_unit),
         .advance   (xfer_done),
         .reload    (wrap),
         .cur       (ptr_cur[p])
      );
   end

   sdma_engine #(.AW(AW)) u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .go        (ctl_q.pending && ctl_q.enable),
      .byte_unit (ctl_q.byte_unit),
      .src       (ptr_cur[0]),
      .dst       (ptr_cur[1]),
      .mem_ready (mem_ready),
      .mem_rdata (mem_rdata),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_byte  (mem_byte),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .busy      (busy),
      .xfer_done (xfer_done)
   );

   always_comb begin
      unique case (cfg_addr)
         REG_CTL: cfg_rdata = AW'(ctl_q);
         REG_SRC: cfg_rdata = ptr_cur[0];
         REG_DST: cfg_rdata = ptr_cur[1];
         default: cfg_rdata = AW'(cnt_q);
      endcase
   end
endmodule

// File: rtl/sdma_channel_sva.sv
module sdma_channel_sva #(
   parameter int AW   = 16,
   parameter int NSRC = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic [NSRC-1:0] req_in,
   input logic            cfg_we,
   input logic [1:0]      cfg_addr,
   input logic            mem_req,
   input logic            mem_we,
   input logic            mem_byte,
   input logic [AW-1:0]   mem_addr,
   input logic [15:0]     mem_wdata,
   input logic            mem_ready,
   input logic            done,
   input logic [7:0]      ctl_bits
);
   logic [3:0] req4;
   always_comb begin
      req4 = '0;
      req4[NSRC-1:0] = req_in;
   end

   // R2: an idle channel latches its selected request
   a_r2_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_bits[1] && req4[ctl_bits[3:2]] && !mem_req && !(cfg_we && cfg_addr == 2'd0))
      |=> ctl_bits[1]);

   // R7: a stalled phase keeps its address and direction
   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready && !cfg_we) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   // R7: a completed read is followed by the write phase
   a_r7_rd_then_wr: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we && mem_ready) |=> (mem_req && mem_we));

   // R7: byte writes carry zero in the upper lane
   a_r7_byte_lane: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && mem_byte) |-> (mem_wdata[15:8] == 8'h00));

   // R4: completion clears the flag, so the bus goes idle next
   a_r4_idle_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && mem_ready) |=> !mem_req);

   // R9: done lasts a single cycle
   a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

bind sdma_channel sdma_channel_sva #(.AW(AW), .NSRC(NSRC)) u_sva (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_in    (req_in),
   .cfg_we    (cfg_we),
   .cfg_addr  (cfg_addr),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_byte  (mem_byte),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata),
   .mem_ready (mem_ready),
   .done      (done),
   .ctl_bits  (ctl_q)
);

// File: tb/sdma_channel_test.sv
`timescale 1ns/1ps
module sdma_channel_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  req_in = '0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_addr = '0;
   logic [15:0] cfg_wdata = '0;
   logic [15:0] cfg_rdata;
   logic        mem_req, mem_we, mem_byte, done;
   logic [15:0] mem_addr, mem_wdata, mem_rdata;
   logic        mem_ready = 1'b1;

   int errors = 0;
   int checks = 0;
   int done_seen = 0;
   int rdy_mode = 0;
   logic [7:0] lf = 8'h5B;

   always #10 clk = ~clk;

   sdma_channel uut (
      .clk(clk), .rst_n(rst_n), .req_in(req_in),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_byte(mem_byte), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready), .done(done)
   );

   function automatic logic [15:0] fdata(input logic [15:0] a);
      return a ^ 16'hC3A5;
   endfunction
   assign mem_rdata = fdata(mem_addr);

   always @(negedge clk) begin
      lf <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      mem_ready <= (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? 1'b0 : lf[0];
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // behavioural reference model
   int m_st = 0;
   logic [15:0] m_src = 0, m_dst = 0, m_s0 = 0, m_d0 = 0, m_data = 0;
   logic [7:0]  m_cnt = 0, m_rel = 0;
   logic        m_ring = 0, m_flag = 0, m_en = 0, m_byte = 0, m_si = 0, m_di = 0, m_done = 0;
   logic [1:0]  m_sel = 0;

   task automatic model_step();
      int nst; logic nf, ne, nd, xfer, busy, last;
      logic [15:0] ns, ndd, ndata, stp; logic [7:0] ncnt;
      if (!rst_n) begin
         m_st = 0; m_src = 0; m_dst = 0; m_s0 = 0; m_d0 = 0; m_data = 0;
         m_cnt = 0; m_rel = 0; m_ring = 0; m_flag = 0; m_en = 0; m_byte = 0;
         m_si = 0; m_di = 0; m_done = 0; m_sel = 0;
         return;
      end
      xfer = (m_st == 2) && mem_ready;
      busy = (m_st != 0);
      last = (m_cnt == 0);
      nf = m_flag;
      if (req_in[m_sel] && !m_flag && !busy) nf = 1;
      if (xfer) nf = 0;
      ne = m_en; nd = 0; ncnt = m_cnt; ns = m_src; ndd = m_dst; nst = m_st; ndata = m_data;
      if (m_st == 0 && m_flag && m_en) nst = 1;
      else if (m_st == 1 && mem_ready) begin nst = 2; ndata = fdata(m_src); end
      else if (m_st == 2 && mem_ready) nst = 0;
      if (xfer) begin
         stp = m_byte ? 16'd1 : 16'd2;
         if (last && m_ring) begin
            ncnt = m_rel; ns = m_s0; ndd = m_d0;
         end else begin
            ncnt = m_cnt - 8'd1;
            if (last) begin ne = 0; nd = 1; end
            if (m_si) ns = m_src + stp;
            if (m_di) ndd = m_dst + stp;
         end
      end
      if (cfg_we) begin
         case (cfg_addr)
            2'd0: begin
               m_ring = cfg_wdata[0]; nf = cfg_wdata[1] & nf; m_sel = cfg_wdata[3:2];
               ne = cfg_wdata[4]; m_byte = cfg_wdata[5]; m_si = cfg_wdata[6]; m_di = cfg_wdata[7];
            end
            2'd1: begin m_s0 = cfg_wdata; ns = cfg_wdata; end
            2'd2: begin m_d0 = cfg_wdata; ndd = cfg_wdata; end
            default: begin ncnt = cfg_wdata[7:0]; m_rel = cfg_wdata[7:0]; end
         endcase
      end
      m_st = nst; m_flag = nf; m_en = ne; m_done = nd; m_cnt = ncnt;
      m_src = ns; m_dst = ndd; m_data = ndata;
   endtask

   task automatic compare();
      logic [15:0] ctl, exp_rd;
      ctl = {8'h00, m_di, m_si, m_byte, m_en, m_sel, m_flag, m_ring};
      check("R5 mem_req", mem_req, m_st != 0);
      if (m_st != 0) begin
         check("R7 mem_we", mem_we, m_st == 2);
         check("R7 mem_addr", mem_addr, (m_st == 2) ? m_dst : m_src);
         check("R7 mem_byte", mem_byte, m_byte);
         if (m_st == 2)
            check("R7 mem_wdata", mem_wdata, m_byte ? {8'h00, m_data[7:0]} : m_data);
      end
      check("R9 done", done, m_done);
      case (cfg_addr)
         2'd0: exp_rd = ctl;
         2'd1: exp_rd = m_src;
         2'd2: exp_rd = m_dst;
         default: exp_rd = {8'h00, m_cnt};
      endcase
      check("R8 cfg_rdata", cfg_rdata, exp_rd);
   endtask

   always @(posedge clk) begin
      model_step();
      #1;
      if (rst_n) begin
         compare();
         if (done) done_seen++;
      end
   end

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk); cfg_we = 1'b0;
   endtask

   task automatic rd_check(input string tag, input logic [1:0] a, input logic [15:0] exp);
      @(negedge clk); cfg_addr = a; #1;
      check(tag, cfg_rdata, exp);
   endtask

   task automatic pulse(input int i);
      @(negedge clk); req_in[i] = 1'b1;
      @(negedge clk); req_in[i] = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rd_check("R1 ctl after reset", 2'd0, 16'h0000);
      rd_check("R1 cnt after reset", 2'd3, 16'h0000);
      check("R1 mem_req after reset", mem_req, 1'b0);
      check("R1 done after reset", done, 1'b0);

      // R2 selected line only, enable off
      wr(2'd0, 16'h0004);
      pulse(0);
      rd_check("R2 unselected line ignored", 2'd0, 16'h0004);
      pulse(1);
      rd_check("R2 selected line sets flag while disabled", 2'd0, 16'h0006);

      // R3 keep on 1, clear on 0, write wins over request
      wr(2'd0, 16'h0006);
      rd_check("R3 write 1 keeps flag", 2'd0, 16'h0006);
      wr(2'd0, 16'h0004);
      rd_check("R3 write 0 clears flag", 2'd0, 16'h0004);
      @(negedge clk); req_in[1] = 1'b1; cfg_we = 1'b1; cfg_addr = 2'd0; cfg_wdata = 16'h0004;
      @(negedge clk); req_in[1] = 1'b0; cfg_we = 1'b0;
      rd_check("R3 write 0 beats same-cycle request", 2'd0, 16'h0004);

      // R5 pending before enable, R9 single transfer with count 0
      wr(2'd1, 16'h0100); wr(2'd2, 16'h0200); wr(2'd3, 16'h0000);
      wr(2'd0, 16'h00C0);
      pulse(0);
      rd_check("R2 flag set with enable off", 2'd0, 16'h00C2);
      wr(2'd0, 16'h00D2);
      idle(10);
      check("R9 done pulse count", done_seen, 1);
      rd_check("R9 enable auto-cleared", 2'd0, 16'h00C0);
      rd_check("R9 count underflow", 2'd3, 16'h00FF);
      rd_check("R8 src +2 for 16-bit", 2'd1, 16'h0102);
      rd_check("R8 dst +2 for 16-bit", 2'd2, 16'h0202);

      // R7/R8/R9 byte unit, fixed destination, three transfers
      wr(2'd1, 16'h0300); wr(2'd2, 16'h0400); wr(2'd3, 16'h0002);
      wr(2'd0, 16'h0078);
      for (int k = 0; k < 3; k++) begin pulse(2); idle(8); end
      rd_check("R8 src +1 per byte", 2'd1, 16'h0303);
      rd_check("R8 fixed dst", 2'd2, 16'h0400);
      check("R9 done after N+1 transfers", done_seen, 2);
      rd_check("R9 enable cleared after N+1", 2'd0, 16'h0068);

      // R4 requests blocked while in flight
      wr(2'd1, 16'h0500); wr(2'd2, 16'h0600); wr(2'd3, 16'h0005);
      wr(2'd0, 16'h00D0);
      rdy_mode = 1;
      pulse(0); idle(3);
      check("R5 read started", mem_req, 1'b1);
      wr(2'd0, 16'h00D0);
      pulse(0);
      rd_check("R4 request during flight ignored", 2'd0, 16'h00D0);
      rdy_mode = 0; idle(6);
      rd_check("R4 transfer completed", 2'd1, 16'h0502);
      rd_check("R4 no second transfer", 2'd3, 16'h0004);

      // R6 disable during accepted transfer
      rdy_mode = 1;
      pulse(0); idle(3);
      wr(2'd0, 16'h00C2);
      rdy_mode = 0; idle(6);
      rd_check("R6 transfer finished after disable", 2'd1, 16'h0504);
      rd_check("R6 count decremented", 2'd3, 16'h0003);
      rd_check("R6 flag cleared, channel disabled", 2'd0, 16'h00C0);

      // R10 ring wrap
      wr(2'd1, 16'h0700); wr(2'd2, 16'h0800); wr(2'd3, 16'h0001);
      wr(2'd0, 16'h00D1);
      pulse(0); idle(8); pulse(0); idle(8);
      rd_check("R10 src reloaded", 2'd1, 16'h0700);
      rd_check("R10 dst reloaded", 2'd2, 16'h0800);
      rd_check("R10 count reloaded", 2'd3, 16'h0001);
      pulse(0); idle(8);
      rd_check("R10 src after wrap", 2'd1, 16'h0702);
      rd_check("R10 still enabled", 2'd0, 16'h00D1);
      check("R10 no done in ring", done_seen, 2);

      // random requests and stalls, ring byte mode, model on every clock
      wr(2'd3, 16'h0003);
      wr(2'd0, 16'h00F1);
      rdy_mode = 2;
      for (int i = 0; i < 1500; i++) begin
         @(negedge clk); req_in = 4'($urandom_range(0, 15));
      end
      req_in = '0; rdy_mode = 0; idle(10);
      summary();
   end
endmodule